// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing half of a small nonvolatile byte store: a 256 x 8 array held in registers. A two-wire bus master reaches the store through it. The block oversamples the bus clock and data lines with the system clock. It finds start and stop conditions, matches its 7-bit device address, and acknowledges bytes. It runs single-byte writes, paged writes, reads from the current address, random reads and sequential reads.

The data pin is open-drain. The block never drives it high. It only asserts a low-active output enable, and the pad and the pull-up form the wired bus line. When a write transfer ends with a stop, the collected bytes go to an internal write-cycle engine. The engine updates the array and holds a busy flag for a fixed number of system clocks. While that flag is high, the block ignores the bus completely. Masters poll for the end of the cycle by sending the device address until they receive an acknowledge.

There is no streaming data path at the block's edge. All transfers go through the two bus pins, so every port is a plain control or status signal.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset, the SDA output enable is low and the busy flag is low.
- R2: A start is SDA falling while SCL is high, and it makes the slave receive a device address. A stop is SDA rising while SCL is high, and it ends the transfer. A repeated start abandons any partly received byte and discards data bytes not yet committed by a stop, so no write cycle runs.
- R3: The device address byte is sent MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal the strap inputs (bit 3 = strap[2]). Bit 0 selects read (1) or write (0). Only on a match does the slave pull SDA low during the ninth clock. Otherwise it stays silent until the next start.
- R4: In a write, the byte after the device address is the word address and the bytes after it are data. The slave acknowledges each of them. Data reaches the array only when the stop arrives.
- R5: During a write, after each data byte the word address bits 1..0 increment modulo 4 while bits 7..2 stay fixed. A fifth data byte therefore overwrites the first.
- R6: A stop that closes a write with at least one data byte raises busy for WR_CYCLES clocks. During that time the slave does not acknowledge its own address and never drives SDA.
- R7: A single address pointer holds the last accessed address plus one, and a read that has no word-address phase returns the byte at that pointer.
- R8: In a read, each master acknowledge on the ninth clock makes the slave send the next byte. The pointer increments across all 8 bits and wraps from 255 to 0.
- R9: If the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start.
- R10: A write carrying only a word address, followed by a repeated start and a read address, returns the byte at that word address and leaves the array and busy flag unchanged.
- R11: The SDA output enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| strap_i | input | 3 | Device address strap bits 3..1 |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_busy_o | output | 1 | Internal write cycle in progress |

## Verification
The hardest situation to reach from the pins is a bus request that arrives while the write cycle is still running. The bus must be moving at exactly the moment the hidden busy window is open. The bench creates it by sending a device address directly after the stop of a write, with a cycle length chosen so the ninth clock falls inside the window, and expects no acknowledge. A second hard case is a repeated start that lands in the middle of a byte or after uncommitted data. The bench places the start after four address bits and after an acknowledged data byte, then checks by readback that nothing was written.

// File: rtl/tw_ee_pkg.sv
package tw_ee_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tw_state_e;

  typedef enum logic [1:0] {
    FLD_DEV,
    FLD_WADDR,
    FLD_DATA
  } tw_field_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
  parameter int AW   = 8,
  parameter int PAGE = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-$clog2(PAGE)-1:0] base_i,
  input  logic [PAGE*8-1:0]    data_i,
  input  logic [PAGE-1:0]      mask_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [7:0]           rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(PAGE);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < PAGE; l++) begin
        if (mask_i[l]) mem[{base_i, PW'(l)}] <= data_i[l*8 +: 8];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/tw_write_engine.sv
module tw_write_engine #(
  parameter int AW        = 8,
  parameter int PAGE      = 4,
  parameter int WR_CYCLES = 400
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [AW-$clog2(PAGE)-1:0] base_i,
  input  logic [PAGE*8-1:0]    data_i,
  input  logic [PAGE-1:0]      mask_i,
  output logic                 busy_o,
  output logic                 mem_we_o,
  output logic [AW-$clog2(PAGE)-1:0] mem_base_o,
  output logic [PAGE*8-1:0]    mem_data_o,
  output logic [PAGE-1:0]      mem_mask_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      remain_q   <= '0;
      mem_we_o   <= 1'b0;
      mem_base_o <= '0;
      mem_data_o <= '0;
      mem_mask_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (req_i && !busy_o) begin
        busy_o     <= 1'b1;
        remain_q   <= CW'(WR_CYCLES - 1);
        mem_we_o   <= 1'b1;
        mem_base_o <= base_i;
        mem_data_o <= data_i;
        mem_mask_o <= mask_i;
      end else if (busy_o) begin
        if (remain_q == '0) busy_o <= 1'b0;
        else remain_q <= remain_q - 1'b1;
      end
    end
  end

  // R6: a commit request never overlaps a running cycle
  a_r6_no_req_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !busy_o);
  // R6: a commit always carries at least one data byte
  a_r6_req_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (mask_i != '0));
  // R6: the array is written exactly as busy rises
  a_r6_write_starts_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $rose(busy_o));
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
  import tw_ee_pkg::*;
#(
  parameter int AW   = 8,
  parameter int PAGE = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [2:0]           strap_i,
  input  logic                 busy_i,
  input  logic [7:0]           rd_data_i,
  output logic [AW-1:0]        ptr_o,
  output logic                 req_o,
  output logic [AW-$clog2(PAGE)-1:0] base_o,
  output logic [PAGE*8-1:0]    data_o,
  output logic [PAGE-1:0]      mask_o,
  output logic                 sda_oe_o
);
  localparam int PW = $clog2(PAGE);

  tw_state_e  state_q;
  tw_field_e  field_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q, txsh_q;
  logic       is_read_q, wr_xfer_q, mack_q;
  logic [AW-1:0] ptr_q;
  logic [7:0] pbuf_q [PAGE];
  logic [PAGE-1:0] pmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      field_q   <= FLD_DEV;
      cnt_q     <= '0;
      shreg_q   <= '0;
      txsh_q    <= '0;
      is_read_q <= 1'b0;
      wr_xfer_q <= 1'b0;
      mack_q    <= 1'b0;
      ptr_q     <= '0;
      pmask_q   <= '0;
      req_o     <= 1'b0;
      sda_oe_o  <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf_q[i] <= '0;
    end else begin
      req_o <= 1'b0;
      if (busy_i) begin
        state_q   <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        pmask_q   <= '0;
        wr_xfer_q <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_RX;
        field_q   <= FLD_DEV;
        cnt_q     <= '0;
        sda_oe_o  <= 1'b0;
        pmask_q   <= '0;
        wr_xfer_q <= 1'b0;
      end else if (stop_i) begin
        if (wr_xfer_q && (pmask_q != '0)) req_o <= 1'b1;
        state_q   <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        wr_xfer_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              case (field_q)
                FLD_DEV: begin
                  if (shreg_q[7:1] == {DEV_TYPE, strap_i}) begin
                    is_read_q <= shreg_q[0];
                    wr_xfer_q <= ~shreg_q[0];
                    state_q   <= ST_ACK;
                    sda_oe_o  <= 1'b1;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                FLD_WADDR: begin
                  ptr_q    <= shreg_q[AW-1:0];
                  pmask_q  <= '0;
                  state_q  <= ST_ACK;
                  sda_oe_o <= 1'b1;
                end
                default: begin
                  pbuf_q[ptr_q[PW-1:0]]  <= shreg_q;
                  pmask_q[ptr_q[PW-1:0]] <= 1'b1;
                  ptr_q    <= {ptr_q[AW-1:PW], PW'(ptr_q[PW-1:0] + 1'b1)};
                  state_q  <= ST_ACK;
                  sda_oe_o <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              if (field_q == FLD_DEV && is_read_q) begin
                state_q  <= ST_TX;
                txsh_q   <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                cnt_q    <= '0;
              end else begin
                field_q <= (field_q == FLD_DEV) ? FLD_WADDR : FLD_DATA;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_MACK;
                ptr_q    <= ptr_q + 1'b1;
              end else begin
                txsh_q   <= {txsh_q[6:0], 1'b0};
                sda_oe_o <= ~txsh_q[6];
                cnt_q    <= cnt_q + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                state_q  <= ST_TX;
                txsh_q   <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                cnt_q    <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign base_o = ptr_q[AW-1:PW];
  assign mask_o = pmask_q;
  for (genvar g = 0; g < PAGE; g++) begin : g_pack
    assign data_o[g*8 +: 8] = pbuf_q[g];
  end

  // R11: the enable moves only while the clock line is low
  a_r11_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
  // R6: no drive at all while a write cycle runs
  a_r6_silent_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_o);
  // R3: an address acknowledge implies a full match
  a_r3_ack_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && field_q == FLD_DEV) |-> (shreg_q[7:1] == {DEV_TYPE, strap_i}));
  // R5: upper address bits hold through a run of data bytes
  a_r5_page_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_q == FLD_DATA && state_q != ST_IDLE && $past(field_q) == FLD_DATA
     && $past(state_q) != ST_IDLE) |-> $stable(ptr_q[AW-1:PW]));
  // R9: an idle slave leaves the line released
  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 4,
  parameter int WR_CYCLES   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       wr_busy_o
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = ADDR_W - PW;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] rd_data;
  logic req;
  logic [BW-1:0] req_base, mem_base;
  logic [PAGE_BYTES*8-1:0] req_data, mem_data;
  logic [PAGE_BYTES-1:0] req_mask, mem_mask;
  logic mem_we;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tw_slave_fsm #(.AW(ADDR_W), .PAGE(PAGE_BYTES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_det),
    .stop_i(stop_det), .strap_i(strap_i), .busy_i(wr_busy_o),
    .rd_data_i(rd_data), .ptr_o(ptr), .req_o(req), .base_o(req_base),
    .data_o(req_data), .mask_o(req_mask), .sda_oe_o(sda_oe_o)
  );

  tw_write_engine #(.AW(ADDR_W), .PAGE(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .base_i(req_base),
    .data_i(req_data), .mask_i(req_mask), .busy_o(wr_busy_o),
    .mem_we_o(mem_we), .mem_base_o(mem_base), .mem_data_o(mem_data),
    .mem_mask_o(mem_mask)
  );

  tw_mem_array #(.AW(ADDR_W), .PAGE(PAGE_BYTES)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we), .base_i(mem_base),
    .data_i(mem_data), .mask_i(mem_mask), .rd_addr_i(ptr), .rd_data_o(rd_data)
  );
endmodule

// File: tb/tw_eeprom_slave_tb.sv
module tw_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  localparam logic [15:0] VEC [8] = '{16'h005A, 16'hFFA5, 16'h37C3, 16'h8001,
                                      16'h7EFE, 16'h0199, 16'hFE3C, 16'h1081};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = STRAP;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_run = 0, n_fail = 0, glitch = 0;
  bit   done = 0;
  logic [7:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_eeprom_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .wr_busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1; hq(); scl = 1; hq(); sda_m = 0; hq(); scl = 0; hq();
  endtask

  task automatic m_stop();
    sda_m = 0; hq(); scl = 1; hq(); sda_m = 1; hq();
  endtask

  task automatic m_bit(input logic b, output logic r);
    logic early;
    sda_m = b; hq(); scl = 1;
    repeat (3) @(negedge clk);
    early = sda_line;
    repeat (Q - 3) @(negedge clk);
    r = sda_line;
    if (early !== r) glitch++;  // R11 line steady while SCL high
    hq(); scl = 0; hq();
  endtask

  task automatic m_send(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_recv(input bit give_ack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(~give_ack, r);
  endtask

  task automatic poll_ready();
    bit a;
    for (int i = 0; i < 100; i++) begin
      m_start(); m_send(DEV_W, a); m_stop();
      if (a) break;
    end
  endtask

  task automatic write_byte(input logic [7:0] adr, input logic [7:0] dat);
    bit a1, a2, a3;
    m_start(); m_send(DEV_W, a1); m_send(adr, a2); m_send(dat, a3); m_stop();
    chk(a1 && a2 && a3, "R4 write acks", {a1, a2, a3}, 3'b111);
    model[adr] = dat;
  endtask

  task automatic rand_read(input logic [7:0] adr, output logic [7:0] d);
    bit a1, a2, a3;
    m_start(); m_send(DEV_W, a1); m_send(adr, a2);
    m_start(); m_send(DEV_R, a3); m_recv(0, d); m_stop();
    chk(a1 && a2 && a3, "R10 random read acks", {a1, a2, a3}, 3'b111);
  endtask

  initial begin
    repeat (Q) begin
      @(posedge clk);
      if (done) break;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit a;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);

    // table walk: byte write then random read back (R4, R10)
    for (int i = 0; i < 8; i++) begin
      write_byte(VEC[i][15:8], VEC[i][7:0]);
      poll_ready();
      rand_read(VEC[i][15:8], d);
      chk(d == VEC[i][7:0], "R4 byte readback", d, VEC[i][7:0]);
    end

    // R6 ack polling: busy window rejects own address
    write_byte(8'h20, 8'h6D);
    chk(busy == 1'b1, "R6 busy after stop", busy, 1);
    m_start(); m_send(DEV_W, a); m_stop();
    chk(!a, "R6 no ack while busy", a, 0);
    poll_ready();
    chk(busy == 1'b0, "R6 busy ends", busy, 0);
    rand_read(8'h20, d);
    chk(d == 8'h6D, "R6 data after cycle", d, 8'h6D);

    // R3 address match
    m_start(); m_send(8'hA0, a); m_stop();
    chk(!a, "R3 strap mismatch", a, 0);
    m_start(); m_send({4'b1011, STRAP, 1'b0}, a); m_stop();
    chk(!a, "R3 type mismatch", a, 0);
    strap = 3'b000;
    repeat (4) @(negedge clk);
    m_start(); m_send(8'hA0, a); m_stop();
    chk(a, "R3 new strap acks", a, 1);
    strap = STRAP;
    repeat (4) @(negedge clk);

    // R5 page write with wrap of five bytes
    begin
      bit k;
      m_start(); m_send(DEV_W, k); m_send(8'h40, k);
      m_send(8'h11, k); m_send(8'h22, k); m_send(8'h33, k); m_send(8'h44, k);
      m_send(8'h55, k);
      chk(k, "R5 fifth byte acked", k, 1);
      m_stop();
      model[8'h40] = 8'h55; model[8'h41] = 8'h22;
      model[8'h42] = 8'h33; model[8'h43] = 8'h44;
      poll_ready();
      m_start(); m_send(DEV_W, k); m_send(8'h40, k);
      m_start(); m_send(DEV_R, k);
      for (int j = 0; j < 5; j++) begin
        m_recv(j < 4, d);
        chk(d == model[8'h40 + j], "R5 page contents", d, model[8'h40 + j]);
      end
      m_stop();
    end

    // R8 sequential read across the top of the space
    begin
      bit k;
      m_start(); m_send(DEV_W, k); m_send(8'hFE, k);
      m_start(); m_send(DEV_R, k);
      m_recv(1, d); chk(d == 8'h3C, "R8 seq FE", d, 8'h3C);
      m_recv(1, d); chk(d == 8'hA5, "R8 seq FF", d, 8'hA5);
      m_recv(0, d); chk(d == 8'h5A, "R8 wrap to 00", d, 8'h5A);
      m_stop();
      // R7 current-address read continues at 01
      m_start(); m_send(DEV_R, k); m_recv(0, d);
      chk(d == 8'h99, "R7 current address", d, 8'h99);
      // R9 after master NACK the slave stays silent
      m_recv(0, d);
      chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
      m_stop();
    end

    // R2 repeated start after uncommitted data discards it
    begin
      bit k;
      logic r;
      m_start(); m_send(DEV_W, k); m_send(8'h60, k); m_send(8'h77, k);
      m_start(); m_send(DEV_R, k); m_recv(0, d); m_stop();
      chk(busy == 1'b0, "R2 no write cycle after abort", busy, 0);
      rand_read(8'h60, d);
      chk(d == 8'h00, "R2 aborted data not stored", d, 0);
      // R2 repeated start in the middle of an address byte
      m_start();
      for (int j = 7; j >= 4; j--) m_bit(DEV_W[j], r);
      rand_read(8'h37, d);
      chk(d == 8'hC3, "R2 mid-byte restart", d, 8'hC3);
    end

    // R10 random read leaves busy low
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R10 no write from random read", busy, 0);

    chk(glitch == 0, "R11 data steady while SCL high", glitch, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule